// File: doc/BRIEF.md
# Clock Output Mode Controller

This block decides what each shared pin of a multi-output clock generator does, and in what state each clock output sits. A static role field per pin makes the pin either a clock output or one of three control inputs: master output enable, power-down, or configuration select. The controller samples the control pins through a two-flop synchronizer on the reference clock. From them it derives per-pin output-enable and force-low controls, a power-down request for the oscillator and divider domains, and the choice between two stored configuration words.

A disabled clock pin either floats or drives logic 0. Two separate bits choose this state, one for disables caused by output enable and one for disables caused by power-down. After power-down ends, and while a configuration change is pending, the outputs stay disabled until a programmable settle count runs out. This models the restart time of the analog parts, which are outside this block. Each pin also carries a normalized drive-strength code for its pad.

Top module: `clock_mode_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, every pin_oe and pin_force_low bit is 0, pd_req is 0, cfg_sel is 1, cfg_active equals cfg_set1 and every pin_drive field is 2'b01.
- R2: The role field encodings are 2'b00 clock, 2'b01 output enable, 2'b10 power-down and 2'b11 configuration select. A pin whose role is not clock always has pin_oe and pin_force_low at 0. Only clock-role pins are ever enabled.
- R3: When any output-enable pin is low, every clock-role pin is disabled and pd_req stays 0. With oem_dis_low at 0 the disabled pin floats (pin_oe 0, pin_force_low 0). With oem_dis_low at 1 it drives low (pin_oe 1, pin_force_low 1).
- R4: When any power-down pin is low, pd_req is 1 and every clock-role pin is disabled in the state chosen by pd_dis_low, with the same encoding as R3. Power-down takes precedence over output enable when both are low.
- R5: After power-down ends, pd_req returns to 0 but the clock-role pins stay disabled in the power-down state for pd_settle further cycles.
- R6: A configuration-select value of 0 selects cfg_set0 and a value of 1 selects cfg_set1. cfg_sel shows the applied choice, and cfg_active always equals the word that cfg_sel names.
- R7: A new configuration-select value is applied only after it has stayed unchanged for csel_settle cycles. Until then, clock-role pins are disabled in the output-enable state. If the value reverts before the count ends, the change is cancelled.
- R8: A function that no pin carries reads as high: with no output-enable pin the outputs are enabled, with no power-down pin pd_req is 0, and with no select pin configuration 1 is applied.
- R9: pin_drive per pin maps drive_raw 2'b00 to 2'b00 (low), 2'b01 to 2'b01 (standard), 2'b10 to 2'b10 (high), and the unused 2'b11 to 2'b01 (standard).
- R10: A control pin change reaches the outputs on the third rising clock edge after it is driven. It is not visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_role | input | 2*NUM_PINS | Role field per pin, pin i at bits [2i+1:2i] |
| pin_in | input | NUM_PINS | Digital value read from each pad |
| oem_dis_low | input | 1 | Output-enable disable state: 0 float, 1 drive low |
| pd_dis_low | input | 1 | Power-down disable state: 0 float, 1 drive low |
| pd_settle | input | CNT_W | Cycles the outputs stay disabled after power-down ends |
| csel_settle | input | CNT_W | Cycles a new select value must hold before it applies |
| cfg_set0 | input | CFG_W | Stored configuration word 0 |
| cfg_set1 | input | CFG_W | Stored configuration word 1 |
| drive_raw | input | 2*NUM_PINS | Programmed drive-strength field per pin |
| pin_oe | output | NUM_PINS | Pad output driver enable |
| pin_force_low | output | NUM_PINS | Pad drives 0 instead of the clock |
| pin_drive | output | 2*NUM_PINS | Normalized drive-strength code per pin |
| pd_req | output | 1 | Power-down request to oscillator and dividers |
| cfg_sel | output | 1 | Applied configuration index |
| cfg_active | output | CFG_W | Applied configuration word |

## Verification
Power-down and master output enable can both be asserted in the same cycle, and each asks for a different disabled state. The bench programs them with opposite disable bits, float for output enable and drive low for power-down, and pulls both control pins low on the same clock edge. The result is judged by the disabled state seen on the clock pins. It must be drive low while power-down is active and during its settle window. Once that window ends and output enable is still low, it must change to float.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [1:0] {
    ROLE_CLK  = 2'b00,
    ROLE_OEM  = 2'b01,
    ROLE_PWDN = 2'b10,
    ROLE_CSEL = 2'b11
  } pin_role_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_STD  = 2'b01,
    DRV_HIGH = 2'b10
  } drive_e;

  // Fold the unused code onto the standard strength.
  function automatic logic [1:0] norm_drive(input logic [1:0] raw);
    logic [1:0] res;
    case (raw)
      DRV_LOW:  res = DRV_LOW;
      DRV_HIGH: res = DRV_HIGH;
      default:  res = DRV_STD;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cmc_sync.sv
module cmc_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cmc_role_decode.sv
module cmc_role_decode
  import cmc_pkg::*;
#(
  parameter int NUM_PINS = 5
) (
  input  logic [2*NUM_PINS-1:0] pin_role,
  input  logic [NUM_PINS-1:0]   pin_sync,
  output logic [NUM_PINS-1:0]   is_clk,
  output logic                  oem_ok,
  output logic                  pwdn_ok,
  output logic                  csel_val
);
  logic [NUM_PINS-1:0] oem_mask;
  logic [NUM_PINS-1:0] pwdn_mask;
  logic [NUM_PINS-1:0] csel_mask;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_role
    assign is_clk[i]    = (pin_role[2*i +: 2] == ROLE_CLK);
    assign oem_mask[i]  = (pin_role[2*i +: 2] == ROLE_OEM);
    assign pwdn_mask[i] = (pin_role[2*i +: 2] == ROLE_PWDN);
    assign csel_mask[i] = (pin_role[2*i +: 2] == ROLE_CSEL);
  end

  // A function with no pin reads high, like an open pulled-up pad.
  assign oem_ok   = &(pin_sync | ~oem_mask);
  assign pwdn_ok  = &(pin_sync | ~pwdn_mask);
  assign csel_val = &(pin_sync | ~csel_mask);
endmodule

// File: rtl/cmc_sequencer.sv
module cmc_sequencer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwdn_ok,
  input  logic             csel_val,
  input  logic [CNT_W-1:0] pd_settle,
  input  logic [CNT_W-1:0] csel_settle,
  output logic             pd_active,
  output logic             pd_hold,
  output logic             cs_hold,
  output logic             cur_sel
);
  logic [CNT_W-1:0] pd_cnt;
  logic [CNT_W-1:0] cs_cnt;

  assign pd_active = ~pwdn_ok;
  assign pd_hold   = pd_active | (pd_cnt != '0);
  assign cs_hold   = (csel_val != cur_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_cnt <= '0;
    end else if (pd_active) begin
      pd_cnt <= pd_settle;
    end else if (pd_cnt != '0) begin
      pd_cnt <= pd_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_cnt  <= '0;
      cur_sel <= 1'b1;
    end else if (!cs_hold) begin
      cs_cnt <= csel_settle;
    end else if (cs_cnt != '0) begin
      cs_cnt <= cs_cnt - 1'b1;
    end else begin
      cur_sel <= csel_val;
    end
  end
endmodule

// File: rtl/cmc_pin_stage.sv
module cmc_pin_stage
  import cmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       is_clk,
  input  logic       out_en,
  input  logic       dis_low,
  input  logic [1:0] drive_raw,
  output logic       oe,
  output logic       force_low,
  output logic [1:0] drive
);
  always_ff @(posedge clk) begin
    if (rst) begin
      oe        <= 1'b0;
      force_low <= 1'b0;
      drive     <= DRV_STD;
    end else begin
      drive <= norm_drive(drive_raw);
      if (!is_clk) begin
        oe        <= 1'b0;
        force_low <= 1'b0;
      end else if (out_en) begin
        oe        <= 1'b1;
        force_low <= 1'b0;
      end else begin
        oe        <= dis_low;
        force_low <= dis_low;
      end
    end
  end
endmodule

// File: rtl/clock_mode_ctrl.sv
module clock_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int NUM_PINS = 5,
  parameter int CFG_W    = 16,
  parameter int CNT_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*NUM_PINS-1:0] pin_role,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  oem_dis_low,
  input  logic                  pd_dis_low,
  input  logic [CNT_W-1:0]      pd_settle,
  input  logic [CNT_W-1:0]      csel_settle,
  input  logic [CFG_W-1:0]      cfg_set0,
  input  logic [CFG_W-1:0]      cfg_set1,
  input  logic [2*NUM_PINS-1:0] drive_raw,
  output logic [NUM_PINS-1:0]   pin_oe,
  output logic [NUM_PINS-1:0]   pin_force_low,
  output logic [2*NUM_PINS-1:0] pin_drive,
  output logic                  pd_req,
  output logic                  cfg_sel,
  output logic [CFG_W-1:0]      cfg_active
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] is_clk;
  logic oem_ok, pwdn_ok, csel_val;
  logic pd_active, pd_hold, cs_hold, cur_sel;
  logic out_en, dis_low;

  cmc_sync #(.W(NUM_PINS), .RST_VAL({NUM_PINS{1'b1}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  cmc_role_decode #(.NUM_PINS(NUM_PINS)) u_decode (
    .pin_role (pin_role),
    .pin_sync (pin_sync),
    .is_clk   (is_clk),
    .oem_ok   (oem_ok),
    .pwdn_ok  (pwdn_ok),
    .csel_val (csel_val)
  );

  cmc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .pwdn_ok     (pwdn_ok),
    .csel_val    (csel_val),
    .pd_settle   (pd_settle),
    .csel_settle (csel_settle),
    .pd_active   (pd_active),
    .pd_hold     (pd_hold),
    .cs_hold     (cs_hold),
    .cur_sel     (cur_sel)
  );

  // Power-down owns the disabled state whenever it is involved.
  assign out_en  = oem_ok & ~pd_hold & ~cs_hold;
  assign dis_low = pd_hold ? pd_dis_low : oem_dis_low;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    cmc_pin_stage u_stage (
      .clk       (clk),
      .rst       (rst),
      .is_clk    (is_clk[i]),
      .out_en    (out_en),
      .dis_low   (dis_low),
      .drive_raw (drive_raw[2*i +: 2]),
      .oe        (pin_oe[i]),
      .force_low (pin_force_low[i]),
      .drive     (pin_drive[2*i +: 2])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_req     <= 1'b0;
      cfg_sel    <= 1'b1;
      cfg_active <= cfg_set1;
    end else begin
      pd_req     <= pd_active;
      cfg_sel    <= cur_sel;
      cfg_active <= cur_sel ? cfg_set1 : cfg_set0;
    end
  end
endmodule

// File: rtl/clock_mode_ctrl_chk.sv
module clock_mode_ctrl_chk #(
  parameter int NUM_PINS = 5,
  parameter int CFG_W    = 16,
  parameter int CNT_W    = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic [2*NUM_PINS-1:0] pin_role,
  input logic [CNT_W-1:0]      pd_settle,
  input logic [CFG_W-1:0]      cfg_set0,
  input logic [CFG_W-1:0]      cfg_set1,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [NUM_PINS-1:0]   pin_force_low,
  input logic [2*NUM_PINS-1:0] pin_drive,
  input logic                  pd_req,
  input logic                  cfg_sel,
  input logic [CFG_W-1:0]      cfg_active
);
  logic [NUM_PINS-1:0] clk_drv;
  logic [NUM_PINS-1:0] ctrl_mask;
  logic [NUM_PINS-1:0] bad_drv;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      ctrl_mask[i] = (pin_role[2*i +: 2] != 2'b00);
      bad_drv[i]   = (pin_drive[2*i +: 2] == 2'b11);
    end
  end

  assign clk_drv = pin_oe & ~pin_force_low;

  // R2
  ctrl_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((pin_oe | pin_force_low) & $past(ctrl_mask)) == '0);

  // R4
  pd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    pd_req |-> (clk_drv == '0));

  // R5
  pd_settle_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pd_req) && ($past(pd_settle) != '0)) |-> (clk_drv == '0));

  // R6
  cfg_match_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_active == (cfg_sel ? $past(cfg_set1) : $past(cfg_set0)));

  // R7
  csel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_sel) |-> ($past(clk_drv) == '0));

  // R9
  drive_legal_chk: assert property (@(posedge clk) disable iff (rst)
    bad_drv == '0);
endmodule

bind clock_mode_ctrl clock_mode_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .CFG_W    (CFG_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .pin_role      (pin_role),
  .pd_settle     (pd_settle),
  .cfg_set0      (cfg_set0),
  .cfg_set1      (cfg_set1),
  .pin_oe        (pin_oe),
  .pin_force_low (pin_force_low),
  .pin_drive     (pin_drive),
  .pd_req        (pd_req),
  .cfg_sel       (cfg_sel),
  .cfg_active    (cfg_active)
);

// File: tb/clock_mode_ctrl_bench.sv
module clock_mode_ctrl_bench;
  localparam int NP = 5;
  localparam int CW = 16;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2*NP-1:0] pin_role;
  logic [NP-1:0]   pin_in;
  logic            oem_dis_low, pd_dis_low;
  logic [TW-1:0]   pd_settle, csel_settle;
  logic [CW-1:0]   cfg_set0, cfg_set1;
  logic [2*NP-1:0] drive_raw;
  logic [NP-1:0]   pin_oe, pin_force_low;
  logic [2*NP-1:0] pin_drive;
  logic            pd_req, cfg_sel;
  logic [CW-1:0]   cfg_active;

  clock_mode_ctrl #(.NUM_PINS(NP), .CFG_W(CW), .CNT_W(TW)) u_clock_mode_ctrl (
    .clk (clk), .rst (rst), .pin_role (pin_role), .pin_in (pin_in),
    .oem_dis_low (oem_dis_low), .pd_dis_low (pd_dis_low),
    .pd_settle (pd_settle), .csel_settle (csel_settle),
    .cfg_set0 (cfg_set0), .cfg_set1 (cfg_set1), .drive_raw (drive_raw),
    .pin_oe (pin_oe), .pin_force_low (pin_force_low), .pin_drive (pin_drive),
    .pd_req (pd_req), .cfg_sel (cfg_sel), .cfg_active (cfg_active)
  );

  always #10 clk = ~clk;

  typedef struct {
    string           tag;
    logic [NP-1:0]   oe;
    logic [NP-1:0]   fl;
    logic            pd;
    logic            sel;
    logic [CW-1:0]   act;
    logic [2*NP-1:0] drv;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  function automatic logic [2*NP-1:0] exp_drive(input logic [2*NP-1:0] raw);
    logic [2*NP-1:0] r;
    for (int i = 0; i < NP; i++)
      r[2*i +: 2] = (raw[2*i +: 2] == 2'b11) ? 2'b01 : raw[2*i +: 2];
    return r;
  endfunction

  // Clock-role pins share one state; control pins are quiet.
  task automatic expect_pins(input string tag, input bit en, input bit low,
                             input bit pd, input bit sel);
    exp_t e;
    e.tag = tag;
    for (int i = 0; i < NP; i++) begin
      bit isclk = (pin_role[2*i +: 2] == 2'b00);
      e.oe[i] = isclk && (en || low);
      e.fl[i] = isclk && !en && low;
    end
    e.pd  = pd;
    e.sel = sel;
    e.act = sel ? cfg_set1 : cfg_set0;
    e.drv = exp_drive(drive_raw);
    sb_q.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // Monitor: compare queued expectations after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        n_vec++;
        if (pin_oe !== e.oe || pin_force_low !== e.fl || pd_req !== e.pd ||
            cfg_sel !== e.sel || cfg_active !== e.act || pin_drive !== e.drv) begin
          n_bad++;
          $display("FAIL %s: oe=%b fl=%b pd=%b sel=%b act=%h drv=%b / exp oe=%b fl=%b pd=%b sel=%b act=%h drv=%b",
                   e.tag, pin_oe, pin_force_low, pd_req, cfg_sel, cfg_active, pin_drive,
                   e.oe, e.fl, e.pd, e.sel, e.act, e.drv);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  // Driver
  initial begin
    pin_role    = {2'b11, 2'b00, 2'b01, 2'b00, 2'b00};
    pin_in      = '1;
    oem_dis_low = 1'b0;
    pd_dis_low  = 1'b1;
    pd_settle   = 16'd20;
    csel_settle = 16'd10;
    cfg_set0    = 16'hA5A5;
    cfg_set1    = 16'h5A5A;
    drive_raw   = {2'b00, 2'b11, 2'b10, 2'b01, 2'b00};
    cyc(2);
    // R1 reset state, all drive fields standard
    begin
      exp_t e;
      e.tag = "R1 reset"; e.oe = '0; e.fl = '0; e.pd = 1'b0; e.sel = 1'b1;
      e.act = cfg_set1; e.drv = {NP{2'b01}};
      sb_q.push_back(e);
    end
    rst = 1'b0;
    cyc(5);
    // R8 R9 R2: pulled-up controls, normal run, drive mapping
    expect_pins("R8 R9 R2 idle", 1'b1, 1'b0, 1'b0, 1'b1);

    // R10 latency of the output-enable pin, R3 float state
    pin_in[2] = 1'b0;
    cyc(2);
    expect_pins("R10 not before third edge", 1'b1, 1'b0, 1'b0, 1'b1);
    cyc(1);
    expect_pins("R10 R3 oe low float", 1'b0, 1'b0, 1'b0, 1'b1);
    oem_dis_low = 1'b1;
    cyc(2);
    expect_pins("R3 oe low drive low", 1'b0, 1'b1, 1'b0, 1'b1);
    pin_in[2] = 1'b1;
    cyc(5);
    expect_pins("R3 oe released", 1'b1, 1'b0, 1'b0, 1'b1);

    // R7 R6 configuration select to 0
    pin_in[4] = 1'b0;
    cyc(6);
    expect_pins("R7 select settling", 1'b0, 1'b1, 1'b0, 1'b1);
    cyc(20);
    expect_pins("R6 select set0", 1'b1, 1'b0, 1'b0, 1'b0);
    // R7 short revert cancels
    pin_in[4] = 1'b1;
    cyc(3);
    expect_pins("R7 revert hold", 1'b0, 1'b1, 1'b0, 1'b0);
    pin_in[4] = 1'b0;
    cyc(15);
    expect_pins("R7 revert cancelled", 1'b1, 1'b0, 1'b0, 1'b0);

    // New roles: pin1 output enable, pin2 power-down
    pin_role    = {2'b11, 2'b00, 2'b10, 2'b01, 2'b00};
    oem_dis_low = 1'b0;
    pd_dis_low  = 1'b1;
    cyc(5);
    expect_pins("R2 roles moved", 1'b1, 1'b0, 1'b0, 1'b0);
    // R4 power-down and output enable in the same cycle
    pin_in[1] = 1'b0;
    pin_in[2] = 1'b0;
    cyc(5);
    expect_pins("R4 pd over oe", 1'b0, 1'b1, 1'b1, 1'b0);
    // R5 release power-down, output enable still low
    pin_in[2] = 1'b1;
    cyc(8);
    expect_pins("R5 pd settle window", 1'b0, 1'b1, 1'b0, 1'b0);
    cyc(25);
    expect_pins("R5 R3 after settle oe float", 1'b0, 1'b0, 1'b0, 1'b0);
    pin_in[1] = 1'b1;
    cyc(5);
    expect_pins("R3 oe released again", 1'b1, 1'b0, 1'b0, 1'b0);

    // R8 no select pin: configuration 1 applies
    pin_role = {2'b00, 2'b00, 2'b10, 2'b01, 2'b00};
    cyc(20);
    expect_pins("R8 no select pin", 1'b1, 1'b0, 1'b0, 1'b1);

    cyc(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule